// File: doc/BRIEF.md
# Masked Vector Add-with-Carry Unit

This unit adds two vectors of 64 unsigned 32-bit elements lane by lane. Each lane also adds one carry bit taken from a predicate word, and reports its own carry-out into a second predicate word. Each predicate word gives every lane a 4-bit field: lane i owns bits [4*i+3 : 4*i]. Signed 32-bit data uses the same adder, because the operands are treated as raw bit patterns.

A lane-enable predicate, in the same 4-bit-per-lane layout, picks the lanes that take part. A disabled lane writes zero to its result element and zero to its carry field. One input strobe starts an operation. The result vector, the carry-out predicate and an output strobe all come from one register stage, one clock later. Chaining passes, by feeding each carry-out predicate back as the next carry-in, builds arithmetic wider than 32 bits.

Top module: `vec_carry_adder`

## Requirements
- R1: For an enabled lane i, result element i (bits [32*i+31 : 32*i]) equals the low 32 bits of opA element i + opB element i + that lane's carry-in bit, with all three taken as unsigned.
- R2: For an enabled lane, carry field i becomes 4'b0001 when that unsigned sum is greater than 0xFFFFFFFF, and 4'b0000 otherwise.
- R3: The carry-in of lane i is bit 4*i of carryIn. Bits 4*i+1 to 4*i+3 have no effect on any output.
- R4: Lane i is enabled exactly when bit 4*i of laneMask is 1. The other three bits of its mask field have no effect. A disabled lane produces a zero result element and a zero carry field.
- R5: outValid is 1 in the cycle after a clock edge that samples inValid high. After an edge that samples inValid low, outValid is 0. Results and the carry-out predicate update at that same edge.
- R6: While inValid is low, sumOut and carryOut keep their previous values.
- R7: A synchronous active-high rst clears outValid, sumOut and carryOut at the next clock edge.
- R8: Operands that hold signed values get exactly the unsigned treatment. For example, 0x80000000 + 0xFFFFFFFE + 1 gives result 0x7FFFFFFF and a carry of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Starts an operation on the present operands |
| opA | input | 2048 | First operand vector, 64 lanes of 32 bits |
| opB | input | 2048 | Second operand vector, 64 lanes of 32 bits |
| carryIn | input | 256 | Carry-in predicate, one 4-bit field per lane |
| laneMask | input | 256 | Lane-enable predicate, one 4-bit field per lane |
| sumOut | output | 2048 | Registered result vector |
| carryOut | output | 256 | Registered carry-out predicate |
| outValid | output | 1 | High for one cycle after each accepted operation |

## Verification
The carry-in and the overflow detection can meet in one lane in one cycle. A lane whose operands sum to exactly 0xFFFFFFFF overflows only because of its carry-in bit. The bench places such a lane next to lanes that overflow from their operands alone and lanes that do not overflow at all. It judges every result element and every carry field against a model of 33-bit arithmetic. Masking also falls in that same cycle. The bench disables chosen lanes whose inputs would otherwise overflow, and expects zero fields for them while their enabled neighbours still carry.

// File: rtl/vca_pkg.sv
package vca_pkg;
  parameter int DEF_LANES  = 64;
  parameter int DEF_ELEM_W = 32;
  parameter int DEF_FIELD_W = 4;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic load;   // capture lane results this edge
    logic clear;  // zero the result registers
  } vcaStrobeT;
endpackage

// File: rtl/vca_ctrl.sv
module vca_ctrl
  import vca_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output vcaStrobeT strobe,
  output logic      outValid
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/vca_lane.sv
module vca_lane #(
  parameter int ELEM_W  = 32,
  parameter int FIELD_W = 4
) (
  input  logic [ELEM_W-1:0]  a,
  input  logic [ELEM_W-1:0]  b,
  input  logic               cinBit,
  input  logic               activeBit,
  output logic [ELEM_W-1:0]  sum,
  output logic [FIELD_W-1:0] coutField
);
  localparam int FULL_W = ELEM_W + 1;
  logic [FULL_W-1:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + FULL_W'(cinBit);
    sum = '0;
    coutField = '0;
    if (activeBit) begin
      sum          = full[ELEM_W-1:0];
      coutField[0] = full[ELEM_W];
    end
  end
endmodule

// File: rtl/vca_datapath.sv
module vca_datapath
  import vca_pkg::*;
#(
  parameter int LANES   = DEF_LANES,
  parameter int ELEM_W  = DEF_ELEM_W,
  parameter int FIELD_W = DEF_FIELD_W,
  localparam int VEC_W  = LANES * ELEM_W,
  localparam int PRED_W = LANES * FIELD_W
) (
  input  logic              clk,
  input  vcaStrobeT         strobe,
  input  logic [VEC_W-1:0]  opA,
  input  logic [VEC_W-1:0]  opB,
  input  logic [PRED_W-1:0] carryIn,
  input  logic [PRED_W-1:0] laneMask,
  output logic [VEC_W-1:0]  sumOut,
  output logic [PRED_W-1:0] carryOut
);
  logic [VEC_W-1:0]  sumNext;
  logic [PRED_W-1:0] carryNext;
  logic              unusedPredBits;

  // only the low bit of each predicate field is consumed
  assign unusedPredBits = ^{carryIn, laneMask};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    vca_lane #(.ELEM_W(ELEM_W), .FIELD_W(FIELD_W)) uLane (
      .a        (opA[g*ELEM_W +: ELEM_W]),
      .b        (opB[g*ELEM_W +: ELEM_W]),
      .cinBit   (carryIn[g*FIELD_W]),
      .activeBit(laneMask[g*FIELD_W]),
      .sum      (sumNext[g*ELEM_W +: ELEM_W]),
      .coutField(carryNext[g*FIELD_W +: FIELD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      sumOut   <= '0;
      carryOut <= '0;
    end else if (strobe.load) begin
      sumOut   <= sumNext;
      carryOut <= carryNext;
    end
  end
endmodule

// File: rtl/vec_carry_adder.sv
module vec_carry_adder
  import vca_pkg::*;
#(
  parameter int LANES   = DEF_LANES,
  parameter int ELEM_W  = DEF_ELEM_W,
  parameter int FIELD_W = DEF_FIELD_W,
  localparam int VEC_W  = LANES * ELEM_W,
  localparam int PRED_W = LANES * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [VEC_W-1:0]  opA,
  input  logic [VEC_W-1:0]  opB,
  input  logic [PRED_W-1:0] carryIn,
  input  logic [PRED_W-1:0] laneMask,
  output logic [VEC_W-1:0]  sumOut,
  output logic [PRED_W-1:0] carryOut,
  output logic              outValid
);
  vcaStrobeT strobe;

  vca_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  vca_datapath #(.LANES(LANES), .ELEM_W(ELEM_W), .FIELD_W(FIELD_W)) uData (
    .clk     (clk),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .laneMask(laneMask),
    .sumOut  (sumOut),
    .carryOut(carryOut)
  );
endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
  parameter int LANES   = 64,
  parameter int ELEM_W  = 32,
  parameter int FIELD_W = 4,
  localparam int VEC_W  = LANES * ELEM_W,
  localparam int PRED_W = LANES * FIELD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [VEC_W-1:0]  opA,
  input logic [VEC_W-1:0]  opB,
  input logic [PRED_W-1:0] carryIn,
  input logic [PRED_W-1:0] laneMask,
  input logic [VEC_W-1:0]  sumOut,
  input logic [PRED_W-1:0] carryOut,
  input logic              outValid
);
  localparam int FULL_W = ELEM_W + 1;

  function automatic logic [PRED_W-1:0] lowBitPattern();
    logic [PRED_W-1:0] p = '0;
    for (int i = 0; i < LANES; i++) p[i*FIELD_W] = 1'b1;
    return p;
  endfunction
  localparam logic [PRED_W-1:0] LOW_BITS = lowBitPattern();

  logic prevRst = 1'b0;
  always @(posedge clk) prevRst <= rst;

  // R7: reset seen at the last edge leaves everything cleared
  always @(negedge clk) begin
    if (prevRst) begin
      assert_reset_clears_R7: assert (!outValid && sumOut == '0 && carryOut == '0)
        else $error("R7 outputs not cleared after reset");
    end
  end

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_drops_R5: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(sumOut) && $stable(carryOut)));
  assert_field_shape_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ((carryOut & ~LOW_BITS) == '0));

  for (genvar g = 0; g < LANES; g++) begin : gLaneChk
    assert_inactive_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (inValid && !laneMask[g*FIELD_W]) |=>
        (sumOut[g*ELEM_W +: ELEM_W] == '0 && carryOut[g*FIELD_W +: FIELD_W] == '0));
    assert_lane_sum_R1: assert property (@(posedge clk) disable iff (rst)
      (inValid && laneMask[g*FIELD_W]) |=>
        ({carryOut[g*FIELD_W], sumOut[g*ELEM_W +: ELEM_W]} ==
         ({1'b0, $past(opA[g*ELEM_W +: ELEM_W])} + {1'b0, $past(opB[g*ELEM_W +: ELEM_W])}
          + FULL_W'($past(carryIn[g*FIELD_W])))));
  end
endmodule

bind vec_carry_adder vca_checker #(.LANES(LANES), .ELEM_W(ELEM_W), .FIELD_W(FIELD_W)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
  .carryIn(carryIn), .laneMask(laneMask), .sumOut(sumOut),
  .carryOut(carryOut), .outValid(outValid)
);

// File: tb/sim_vec_carry_adder.sv
module sim_vec_carry_adder;
  localparam int LANES = 64, ELEM_W = 32, FIELD_W = 4;
  localparam int VEC_W = LANES * ELEM_W, PRED_W = LANES * FIELD_W;

  logic clk = 1'b0, rst = 1'b1, inValid = 1'b0;
  logic [VEC_W-1:0]  opA = '0, opB = '0, sumOut;
  logic [PRED_W-1:0] carryIn = '0, laneMask = '0, carryOut;
  logic outValid;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [VEC_W-1:0]  expSum;
  logic [PRED_W-1:0] expCarry;

  always #10 clk = ~clk;  // 50 MHz

  vec_carry_adder u0 (.clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .carryIn(carryIn), .laneMask(laneMask), .sumOut(sumOut), .carryOut(carryOut),
    .outValid(outValid));

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // model from the requirements: 33-bit lane sums, bit 4*i selects carry and enable
  task automatic computeExp(input logic [VEC_W-1:0] a, b, input logic [PRED_W-1:0] c, m);
    expSum = '0; expCarry = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [32:0] full;
      full = {1'b0, a[i*32 +: 32]} + {1'b0, b[i*32 +: 32]} + {32'd0, c[i*4]};
      if (m[i*4]) begin
        expSum[i*32 +: 32] = full[31:0];
        expCarry[i*4 +: 4] = {3'b000, full[32]};
      end
    end
  endtask

  task automatic checkBit(input string req, input logic act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    checks++;
    if (sumOut !== expSum || carryOut !== expCarry) begin
      errors++;
      for (int i = 0; i < LANES; i++) begin
        if (sumOut[i*32 +: 32] !== expSum[i*32 +: 32] || carryOut[i*4 +: 4] !== expCarry[i*4 +: 4]) begin
          $display("FAIL %s: lane %0d actual sum=%h carry=%b expected sum=%h carry=%b", req, i,
            sumOut[i*32 +: 32], carryOut[i*4 +: 4], expSum[i*32 +: 32], expCarry[i*4 +: 4]);
          break;
        end
      end
    end
  endtask

  task automatic issue(input logic [VEC_W-1:0] a, b, input logic [PRED_W-1:0] c, m);
    @(negedge clk);
    opA = a; opB = b; carryIn = c; laneMask = m; inValid = 1'b1;
    computeExp(a, b, c, m);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    checkBit("R7 outValid in reset", outValid, 1'b0);
    checks++;
    if (sumOut !== '0 || carryOut !== '0) begin
      errors++;
      $display("FAIL R7: actual sum/carry nonzero expected zero");
    end
    rst = 1'b0;
  endtask

  task automatic testBoundaries();
    logic [VEC_W-1:0] a = '0, b = '0;
    logic [PRED_W-1:0] c = '0;
    a[0*32 +: 32] = 32'hFFFF_FFFF; b[0*32 +: 32] = 32'd2;                                  // carry 1
    a[1*32 +: 32] = 32'd3;         b[1*32 +: 32] = 32'd2;                                  // carry 0
    a[2*32 +: 32] = 32'h8000_0000; b[2*32 +: 32] = 32'hFFFF_FFFE; c[2*4] = 1'b1;           // R8
    a[3*32 +: 32] = 32'hFFFF_FFFF; b[3*32 +: 32] = 32'd0;         c[3*4] = 1'b1;           // carry from cin only
    a[4*32 +: 32] = 32'hFFFF_FFFE; b[4*32 +: 32] = 32'd1;                                  // exactly max, no carry
    issue(a, b, c, {PRED_W{1'b1}});
    checkBit("R5 outValid after start", outValid, 1'b1);
    checkOutputs("R1 R2 R8 boundary lanes");
    checkBit("R2 lane0 carry", carryOut[0], 1'b1);
    checkBit("R8 lane2 carry", carryOut[8], 1'b1);
    checkBit("R2 lane3 carry from carry-in", carryOut[12], 1'b1);
    checkBit("R2 lane4 no carry at max", carryOut[16], 1'b0);
  endtask

  task automatic testMaskedOff();
    logic [PRED_W-1:0] m = '0;
    for (int i = 0; i < LANES; i++) m[i*4 +: 4] = 4'b1110;  // enable bit cleared
    issue({VEC_W{1'b1}}, {VEC_W{1'b1}}, {PRED_W{1'b1}}, m);
    checkOutputs("R4 fully masked vector");
  endtask

  task automatic testJunkCarryBits();
    logic [VEC_W-1:0] a = '0;
    logic [PRED_W-1:0] c = '0;
    for (int i = 0; i < LANES; i++) begin
      a[i*32 +: 32] = 32'hFFFF_FFFF;
      c[i*4 +: 4] = (i % 2 == 0) ? 4'b1110 : 4'b0001;
    end
    issue(a, '0, c, {PRED_W{1'b1}});
    checkOutputs("R3 upper carry-in bits ignored");
    checkBit("R3 lane0 no carry", carryOut[0], 1'b0);
    checkBit("R3 lane1 carry", carryOut[4], 1'b1);
  endtask

  task automatic testRandomMixed();
    for (int r = 0; r < 6; r++) begin
      logic [VEC_W-1:0] a, b;
      logic [PRED_W-1:0] c, m;
      for (int i = 0; i < VEC_W / 32; i++) begin
        seed = nextRand(seed); a[i*32 +: 32] = seed;
        seed = nextRand(seed); b[i*32 +: 32] = (r % 2 == 0) ? seed : ~a[i*32 +: 32];
      end
      for (int i = 0; i < PRED_W / 32; i++) begin
        seed = nextRand(seed); c[i*32 +: 32] = seed;
        seed = nextRand(seed); m[i*32 +: 32] = seed;
      end
      issue(a, b, c, m);
      checkOutputs("R1 R2 R4 mixed lanes");
    end
  endtask

  task automatic testHoldAndBackToBack();
    logic [VEC_W-1:0]  keepSum;
    logic [PRED_W-1:0] keepCarry;
    keepSum = sumOut; keepCarry = carryOut;
    @(negedge clk);
    opA = {VEC_W{1'b1}}; opB = {VEC_W{1'b1}}; carryIn = {PRED_W{1'b1}};
    @(negedge clk);
    checkBit("R5 outValid low when idle", outValid, 1'b0);
    checks++;
    if (sumOut !== keepSum || carryOut !== keepCarry) begin
      errors++;
      $display("FAIL R6: actual outputs changed expected held");
    end
    // two starts in consecutive cycles
    opA = {LANES{32'd10}}; opB = {LANES{32'd20}}; carryIn = '0; laneMask = {PRED_W{1'b1}};
    inValid = 1'b1;
    @(negedge clk);
    computeExp({LANES{32'd10}}, {LANES{32'd20}}, '0, {PRED_W{1'b1}});
    checkOutputs("R5 first of back-to-back");
    opA = {LANES{32'hFFFF_FFF0}}; opB = {LANES{32'h20}};
    @(negedge clk);
    inValid = 1'b0;
    computeExp({LANES{32'hFFFF_FFF0}}, {LANES{32'h20}}, '0, {PRED_W{1'b1}});
    checkBit("R5 outValid second start", outValid, 1'b1);
    checkOutputs("R5 second of back-to-back");
  endtask

  task automatic testMidReset();
    @(negedge clk);
    opA = {LANES{32'd7}}; opB = {LANES{32'd9}}; laneMask = {PRED_W{1'b1}};
    inValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R7 reset beats start", outValid, 1'b0);
    checks++;
    if (sumOut !== '0 || carryOut !== '0) begin
      errors++;
      $display("FAIL R7: actual outputs nonzero expected zero after reset");
    end
    rst = 1'b0;
  endtask

  initial begin
    testReset();
    testBoundaries();
    testMaskedOff();
    testJunkCarryBits();
    testRandomMixed();
    testHoldAndBackToBack();
    testMidReset();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule